// File: doc/BRIEF.md
# Power Management Event Status and Interrupt Routing

This block keeps the status and enable bits for power management events and turns them into interrupt requests. Two event sources feed it: a power button press and an RTC alarm, each arriving as a one-cycle pulse. Each event sets a sticky status bit. The status bit stays set until software writes a one to it.

A pending event is one whose status bit and enable bit are both set. When any event is pending, the block raises a legacy SMI request, an ACPI SCI request, or both. Two global enable bits choose which of these outputs is active.

The RTC alarm also sets a separate wake status bit, which has its own enable bit. This wake path drives an active-low PME request. The wake path does not depend on the SMI and SCI enables.

The SCI pad can run at either polarity. It can drive push-pull or open-drain.

Software reaches all of the state through a small register bus. The bus takes an address, a write strobe and write data, and returns read data combinationally.

Top module: `pm_event_router`

## Requirements
- R1: A synchronous active-high reset clears every register. After reset, `smi_req`=0, `pme_n`=1, `sci_pad_o`=0 and `sci_pad_oe`=1.
- R2: An event pulse sets its status bit in the event status register (offset 0) on the next clock edge. The power button uses bit 0 and the RTC alarm uses bit 1.
- R3: Writing 1 to a bit of a status register (offset 0 or 3) clears that bit. Writing 0 leaves the bit unchanged.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: An RTC alarm also sets wake status bit 0 (offset 3). The wake status bit and the event status bit are cleared independently of each other.
- R6: `sci` is asserted exactly when the SCI global enable is set and at least one event has both its status bit and its enable bit set. The SCI global enable is offset 2, bit 0. The event enables are at offset 1, with the same bit positions as the status bits.
- R7: `smi_req` is asserted exactly when the SMI global enable is set and at least one event is pending (status and enable both set). The SMI global enable is offset 5, bit 7.
- R8: If both global enables are set, one event asserts `smi_req` and the SCI request together.
- R9: `pme_n` is low exactly when wake status bit 0 and wake enable bit 0 (offset 4) are both set.
- R10: Pad configuration bit 0 (offset 6) selects active-low SCI. When it is set, `sci_pad_o` carries the inverse of the internal SCI request.
- R11: Pad configuration bit 1 (offset 6) selects open-drain drive. In that mode `sci_pad_oe` is high only while `sci_pad_o` is 0. In push-pull mode `sci_pad_oe` is always 1.
- R12: A read returns the register contents. Bits that are not implemented read 0. Offset 7 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pwrbtn_evt | input | 1 | Power button press pulse |
| rtc_alarm_evt | input | 1 | RTC alarm pulse |
| smi_req | output | 1 | Legacy SMI request, active high |
| sci_pad_o | output | 1 | SCI pad value after polarity |
| sci_pad_oe | output | 1 | SCI pad output enable |
| pme_n | output | 1 | Wake request, active low |

## Verification
The assertions check several rules on every cycle:
- set-over-clear priority and write-one-to-clear at each status bit;
- `smi_req`, the SCI request and `pme_n` are never active unless a matching status and enable pair is set;
- an open-drain pad never drives high.

Only the bench scenarios can show the rest:
- the reverse direction, that a pending event does raise each output;
- polarity inversion at the pad;
- writes of 0 leaving status unchanged;
- the readback map, including unimplemented bits and offset 7.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_EVT  = 2;
    localparam int NUM_WAKE = 1;

    localparam int EVT_BTN  = 0;
    localparam int EVT_RTC  = 1;
    localparam int WAKE_RTC = 0;

    localparam int CTRL_SCI_GEN_BIT = 0;
    localparam int LEG_SMI_GEN_BIT  = 7;
    localparam int CFG_LOW_BIT      = 0;
    localparam int CFG_OD_BIT       = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_EVT_STS  = 3'd0,
        A_EVT_EN   = 3'd1,
        A_CTRL     = 3'd2,
        A_WAKE_STS = 3'd3,
        A_WAKE_EN  = 3'd4,
        A_LEG_EN   = 3'd5,
        A_PAD_CFG  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic open_drain;
        logic active_low;
    } pad_cfg_t;

    typedef struct packed {
        logic smi_gen;
        logic sci_gen;
    } route_t;

    function automatic logic any_pending(input logic [NUM_EVT-1:0] sts,
                                         input logic [NUM_EVT-1:0] en);
        return |(sts & en);
    endfunction
endpackage

// File: rtl/pmev_sts_bank.sv
module pmev_sts_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           sts_o[i] <= 1'b0;
            else if (set_i[i]) sts_o[i] <= 1'b1;
            else if (clr_i[i]) sts_o[i] <= 1'b0;
        end

        p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> sts_o[i]);
        p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !sts_o[i]);
        p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
            (sts_o[i] && !clr_i[i]) |=> sts_o[i]);
    end
endmodule

// File: rtl/pmev_sci_pad.sv
module pmev_sci_pad
    import pmev_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level_i,
    input  pad_cfg_t cfg_i,
    output logic     pad_o,
    output logic     pad_oe
);
    always_comb begin
        pad_o  = level_i ^ cfg_i.active_low;
        pad_oe = cfg_i.open_drain ? !pad_o : 1'b1;
    end

    p_od_never_high_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_i.open_drain |-> !(pad_oe && pad_o));
    p_pp_always_drives_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.open_drain |-> pad_oe);
endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
    import pmev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              pwrbtn_evt,
    input  logic              rtc_alarm_evt,
    output logic              smi_req,
    output logic              sci_pad_o,
    output logic              sci_pad_oe,
    output logic              pme_n
);
    logic [NUM_EVT-1:0]  evt_sts, evt_en, evt_set, evt_clr;
    logic [NUM_WAKE-1:0] wake_sts, wake_en, wake_set, wake_clr;
    route_t              route;
    pad_cfg_t            pad_cfg;
    logic                pending, sci_level;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        evt_set          = '0;
        evt_set[EVT_BTN] = pwrbtn_evt;
        evt_set[EVT_RTC] = rtc_alarm_evt;
        wake_set           = '0;
        wake_set[WAKE_RTC] = rtc_alarm_evt;
        evt_clr  = (bus_wr && bus_addr == A_EVT_STS)  ? bus_wdata[NUM_EVT-1:0]  : '0;
        wake_clr = (bus_wr && bus_addr == A_WAKE_STS) ? bus_wdata[NUM_WAKE-1:0] : '0;
    end

    pmev_sts_bank #(.N(NUM_EVT)) u_evt_sts (
        .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(evt_clr), .sts_o(evt_sts));

    pmev_sts_bank #(.N(NUM_WAKE)) u_wake_sts (
        .clk(clk), .rst(rst), .set_i(wake_set), .clr_i(wake_clr), .sts_o(wake_sts));

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_en  <= '0;
            wake_en <= '0;
            route   <= '0;
            pad_cfg <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_EVT_EN:  evt_en  <= bus_wdata[NUM_EVT-1:0];
                A_WAKE_EN: wake_en <= bus_wdata[NUM_WAKE-1:0];
                A_CTRL:    route.sci_gen <= bus_wdata[CTRL_SCI_GEN_BIT];
                A_LEG_EN:  route.smi_gen <= bus_wdata[LEG_SMI_GEN_BIT];
                A_PAD_CFG: begin
                    pad_cfg.active_low <= bus_wdata[CFG_LOW_BIT];
                    pad_cfg.open_drain <= bus_wdata[CFG_OD_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_EVT_STS:  bus_rdata[NUM_EVT-1:0]  = evt_sts;
            A_EVT_EN:   bus_rdata[NUM_EVT-1:0]  = evt_en;
            A_WAKE_STS: bus_rdata[NUM_WAKE-1:0] = wake_sts;
            A_WAKE_EN:  bus_rdata[NUM_WAKE-1:0] = wake_en;
            A_CTRL:     bus_rdata[CTRL_SCI_GEN_BIT] = route.sci_gen;
            A_LEG_EN:   bus_rdata[LEG_SMI_GEN_BIT]  = route.smi_gen;
            A_PAD_CFG: begin
                bus_rdata[CFG_LOW_BIT] = pad_cfg.active_low;
                bus_rdata[CFG_OD_BIT]  = pad_cfg.open_drain;
            end
            default: ;
        endcase
    end

    always_comb begin
        pending   = any_pending(evt_sts, evt_en);
        sci_level = pending && route.sci_gen;
        smi_req   = pending && route.smi_gen;
        pme_n     = !(|(wake_sts & wake_en));
    end

    pmev_sci_pad u_sci_pad (
        .clk(clk), .rst(rst), .level_i(sci_level), .cfg_i(pad_cfg),
        .pad_o(sci_pad_o), .pad_oe(sci_pad_oe));

    p_smi_needs_source_r7: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> ((evt_sts & evt_en) != '0));
    p_sci_needs_source_r6: assert property (@(posedge clk) disable iff (rst)
        sci_level |-> ((evt_sts & evt_en) != '0));
    p_pme_needs_wake_r9: assert property (@(posedge clk) disable iff (rst)
        !pme_n |-> wake_sts[WAKE_RTC]);
    p_rtc_sets_wake_r5: assert property (@(posedge clk) disable iff (rst)
        rtc_alarm_evt |=> (wake_sts[WAKE_RTC] && evt_sts[EVT_RTC]));
    p_hole_reads_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd7) |-> (bus_rdata == '0));
endmodule

// File: tb/pm_event_router_test.sv
module pm_event_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // vector: wr, addr, wdata, btn, rtc, check addr, exp rdata, exp smi, exp sci_o, exp oe, exp pme_n, req tag
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b1,3'd1,8'h03,1'b0,1'b0,3'd1,8'h03,1'b0,1'b0,1'b1,1'b1,4'd12}, // R12 enable write
        {1'b1,3'd2,8'h01,1'b0,1'b0,3'd2,8'h01,1'b0,1'b0,1'b1,1'b1,4'd6},  // R6 sci gen on, nothing pending
        {1'b0,3'd0,8'h00,1'b1,1'b0,3'd0,8'h01,1'b0,1'b1,1'b1,1'b1,4'd2},  // R2 button sets bit0, SCI up
        {1'b1,3'd0,8'h00,1'b0,1'b0,3'd0,8'h01,1'b0,1'b1,1'b1,1'b1,4'd3},  // R3 write 0 no effect
        {1'b1,3'd0,8'h01,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b1,1'b1,4'd3},  // R3 write 1 clears
        {1'b1,3'd5,8'h80,1'b0,1'b0,3'd5,8'h80,1'b0,1'b0,1'b1,1'b1,4'd7},  // R7 smi gen on
        {1'b0,3'd0,8'h00,1'b0,1'b1,3'd0,8'h02,1'b1,1'b1,1'b1,1'b1,4'd8},  // R8 rtc raises both
        {1'b0,3'd0,8'h00,1'b0,1'b0,3'd3,8'h01,1'b1,1'b1,1'b1,1'b1,4'd5},  // R5 wake status set
        {1'b1,3'd4,8'h01,1'b0,1'b0,3'd4,8'h01,1'b1,1'b1,1'b1,1'b0,4'd9},  // R9 wake enable -> pme_n low
        {1'b1,3'd3,8'h01,1'b0,1'b0,3'd3,8'h00,1'b1,1'b1,1'b1,1'b1,4'd5},  // R5 clear wake only
        {1'b1,3'd2,8'h00,1'b0,1'b0,3'd0,8'h02,1'b1,1'b0,1'b1,1'b1,4'd7},  // R7 sci off, smi stays
        {1'b1,3'd6,8'h01,1'b0,1'b0,3'd6,8'h01,1'b1,1'b1,1'b1,1'b1,4'd10}, // R10 active low idle high
        {1'b1,3'd2,8'h01,1'b0,1'b0,3'd2,8'h01,1'b1,1'b0,1'b1,1'b1,4'd10}, // R10 asserted low
        {1'b1,3'd6,8'h03,1'b0,1'b0,3'd6,8'h03,1'b1,1'b0,1'b1,1'b1,4'd11}, // R11 open drain pulls low
        {1'b1,3'd0,8'h02,1'b0,1'b0,3'd0,8'h00,1'b0,1'b1,1'b0,1'b1,4'd11}, // R11 open drain released
        {1'b1,3'd7,8'hFF,1'b0,1'b0,3'd7,8'h00,1'b0,1'b1,1'b0,1'b1,4'd12}, // R12 hole
        {1'b1,3'd1,8'hFF,1'b0,1'b0,3'd1,8'h03,1'b0,1'b1,1'b0,1'b1,4'd12}  // R12 unused bits
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwrbtn_evt = 1'b0, rtc_alarm_evt = 1'b0;
    logic       smi_req, sci_pad_o, sci_pad_oe, pme_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_event_router uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwrbtn_evt(pwrbtn_evt),
        .rtc_alarm_evt(rtc_alarm_evt), .smi_req(smi_req), .sci_pad_o(sci_pad_o),
        .sci_pad_oe(sci_pad_oe), .pme_n(pme_n));

    task automatic step(input logic wr, input logic [2:0] a, input logic [7:0] d,
                        input logic b, input logic r, input logic [2:0] ca);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; pwrbtn_evt = b; rtc_alarm_evt = r;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; pwrbtn_evt = 1'b0; rtc_alarm_evt = 1'b0; bus_addr = ca;
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input string req, input logic [7:0] rd, input logic smi,
                         input logic so, input logic oe, input logic pn);
        n_chk++;
        if (bus_rdata !== rd || smi_req !== smi || sci_pad_o !== so ||
            sci_pad_oe !== oe || pme_n !== pn) begin
            n_bad++;
            $display("FAIL %s: got rd=%h smi=%b sci=%b oe=%b pme_n=%b, expected rd=%h smi=%b sci=%b oe=%b pme_n=%b",
                     req, bus_rdata, smi_req, sci_pad_o, sci_pad_oe, pme_n, rd, smi, so, oe, pn);
        end
    endtask

    task automatic reset_check();
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a);
            #1;
            check("R1 reset state", 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        reset_check();

        for (int i = 0; i < NVEC; i++) begin
            logic [32:0] v;
            v = VEC[i];
            step(v[32], v[31:29], v[28:21], v[20], v[19], v[18:16]);
            check($sformatf("R%0d vector %0d", v[3:0], i), v[15:8], v[7], v[6], v[5], v[4]);
        end

        // R4: button pulse and clear of bit0 in the same cycle; gens on, active-low open drain
        step(1'b1, 3'd0, 8'h01, 1'b1, 1'b0, 3'd0);
        check("R4 event status set wins", 8'h01, 1'b1, 1'b0, 1'b1, 1'b1);
        // R4: rtc pulse with clear of wake bit0; wake enable still 1
        step(1'b1, 3'd3, 8'h01, 1'b0, 1'b1, 3'd3);
        check("R4 wake status set wins", 8'h01, 1'b1, 1'b0, 1'b1, 1'b0);
        bus_addr = 3'd0; #1;
        check("R5 rtc status also set", 8'h03, 1'b1, 1'b0, 1'b1, 1'b0);

        // R1: reset from a busy state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        reset_check();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule